// File: doc/BRIEF.md
# Gap-Framed Serial Packet Receiver

This block sits behind a UART byte engine. It collects incoming bytes into packets, and it uses only idle time on the line to decide where one packet stops and the next begins. No byte value marks a boundary. Idle time is counted in character-time ticks supplied from outside the block. The length of gap that closes a packet depends on a baud-mode select: a short gap in normal mode and a much longer one in low-speed mode.

Each byte is forwarded with a one-byte delay. Because of this delay, the last byte of a packet can carry an end marker once the closing gap has been seen. Every packet carries a 16-bit CRC in its last two bytes. The CRC is the reflected CCITT polynomial with zero start value, and the result is judged by its residue. Three packet counters (received, good and bad) give a running account. The downstream command parser consumes the marked byte stream and the CRC verdict.

Top module: `gap_pkt_rx`

## Requirements
- R1: After a synchronous active-high reset, out_vld, out_sop, out_eop and out_crc_ok are 0 and all three counters are 0.
- R2: A received byte is presented on out_data with out_vld high for one cycle. This happens in the cycle after the next byte is accepted, or in the cycle after the packet closes.
- R3: out_sop is high together with the first byte of each packet, and low for every other byte.
- R4: With slow_mode=0, a packet closes on the 3rd char_tick after its last byte (the gap exceeds 2 character times). That last byte is then presented with out_eop=1.
- R5: With slow_mode=1, a packet closes on the 26th char_tick after its last byte (the gap exceeds 25 character times).
- R6: Each accepted byte restarts the gap count. A char_tick in the same cycle as byte_vld is not counted, and a gap of exactly the limit keeps the packet open.
- R7: out_crc_ok is valid with out_eop. It is 1 exactly when the CRC over every packet byte, including the two trailing CRC bytes, is 0x0000. The CRC uses polynomial x^16+x^12+x^5+1, is processed LSB first (reflected constant 0x8408), starts at 0x0000 and has no final XOR. The trailing CRC is sent low byte first.
- R8: char_tick while no packet is open produces no output and leaves the counters unchanged.
- R9: On each packet close, rx_pkt_cnt increments. good_pkt_cnt increments when out_crc_ok=1 and bad_pkt_cnt increments otherwise. All counters are CNT_W bits wide (default 16) and wrap on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| slow_mode | input | 1 | 1 selects the long closing gap |
| char_tick | input | 1 | One pulse per character time |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_crc_ok | output | 1 | CRC verdict, valid with out_eop |
| rx_pkt_cnt | output | CNT_W | Packets received |
| good_pkt_cnt | output | CNT_W | Packets with good CRC |
| bad_pkt_cnt | output | CNT_W | Packets with bad CRC |

## Verification
The hardest situation to reach is a gap that stops exactly at the limit: a packet held open by precisely 2 (or 25) ticks and then resumed by a byte, sometimes with a tick arriving in the same cycle as that byte. The sweep inserts a tick run of every length from 0 up to the limit between bytes, in both modes, so the boundary is hit repeatedly. Counter wrap is reached by building the bench with a narrow counter width, so a few dozen packets cross overflow.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  // one byte through the reflected CCITT register, LSB first
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/gpr_gap_timer.sv
module gpr_gap_timer #(
  parameter int NORM_GAP = 2,
  parameter int SLOW_GAP = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_vld,
  input  logic char_tick,
  input  logic slow_mode,
  input  logic pkt_open,
  output logic gap_done
);
  localparam int MAXG = (SLOW_GAP > NORM_GAP) ? SLOW_GAP : NORM_GAP;
  localparam int GW   = $clog2(MAXG + 1);

  logic [GW-1:0] gap_cnt;
  logic [GW-1:0] limit;

  assign limit    = slow_mode ? GW'(SLOW_GAP) : GW'(NORM_GAP);
  assign gap_done = pkt_open && !byte_vld && char_tick && (gap_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || byte_vld || gap_done)
      gap_cnt <= '0;
    else if (char_tick && pkt_open)
      gap_cnt <= gap_cnt + 1'b1;
  end

  p_gap_bound_r6: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GW'(MAXG));
  p_byte_clears_gap_r6: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> gap_cnt == '0);
endmodule

// File: rtl/gpr_crc_acc.sv
module gpr_crc_acc
  import gpr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        restart,
  output logic [15:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst)
      crc_q <= '0;
    else if (byte_vld)
      crc_q <= crc_byte(restart ? 16'h0000 : crc_q, byte_data);
  end

  p_crc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> $stable(crc_q));
endmodule

// File: rtl/gap_pkt_rx.sv
module gap_pkt_rx #(
  parameter int NORM_GAP = 2,
  parameter int SLOW_GAP = 25,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             slow_mode,
  input  logic             char_tick,
  output logic             out_vld,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_crc_ok,
  output logic [CNT_W-1:0] rx_pkt_cnt,
  output logic [CNT_W-1:0] good_pkt_cnt,
  output logic [CNT_W-1:0] bad_pkt_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic        pkt_open;
  logic [7:0]  hold_data;
  logic        hold_first;
  logic        gap_done;
  logic [15:0] crc_q;

  gpr_gap_timer #(.NORM_GAP(NORM_GAP), .SLOW_GAP(SLOW_GAP)) u_gap (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .char_tick(char_tick),
    .slow_mode(slow_mode), .pkt_open(pkt_open), .gap_done(gap_done)
  );

  gpr_crc_acc u_crc (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .restart(!pkt_open), .crc_q(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_open     <= 1'b0;
      hold_data    <= '0;
      hold_first   <= 1'b0;
      out_vld      <= 1'b0;
      out_data     <= '0;
      out_sop      <= 1'b0;
      out_eop      <= 1'b0;
      out_crc_ok   <= 1'b0;
      rx_pkt_cnt   <= '0;
      good_pkt_cnt <= '0;
      bad_pkt_cnt  <= '0;
    end else begin
      out_vld    <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_crc_ok <= 1'b0;
      if (byte_vld) begin
        if (pkt_open) begin
          out_vld  <= 1'b1;
          out_data <= hold_data;
          out_sop  <= hold_first;
        end
        hold_data  <= byte_data;
        hold_first <= !pkt_open;
        pkt_open   <= 1'b1;
      end else if (gap_done) begin
        out_vld    <= 1'b1;
        out_data   <= hold_data;
        out_sop    <= hold_first;
        out_eop    <= 1'b1;
        out_crc_ok <= (crc_q == 16'h0000);
        pkt_open   <= 1'b0;
        rx_pkt_cnt <= rx_pkt_cnt + ONE;
        if (crc_q == 16'h0000) good_pkt_cnt <= good_pkt_cnt + ONE;
        else                   bad_pkt_cnt  <= bad_pkt_cnt + ONE;
      end
    end
  end

  p_eop_has_vld_r4: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> out_vld);
  p_crc_ok_only_eop_r7: assert property (@(posedge clk) disable iff (rst)
    out_crc_ok |-> out_eop);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!pkt_open && !byte_vld) |=> !out_vld);
  p_rx_step_r9: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> rx_pkt_cnt == $past(rx_pkt_cnt) + ONE);
  p_good_step_r9: assert property (@(posedge clk) disable iff (rst)
    (out_eop && out_crc_ok) |-> good_pkt_cnt == $past(good_pkt_cnt) + ONE);
  p_bad_step_r9: assert property (@(posedge clk) disable iff (rst)
    (out_eop && !out_crc_ok) |-> bad_pkt_cnt == $past(bad_pkt_cnt) + ONE);
endmodule

// File: tb/test_gap_pkt_rx.sv
module test_gap_pkt_rx;
  localparam int CW = 5;
  localparam int NG = 2;
  localparam int SG = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic slow_mode = 1'b0;
  logic char_tick = 1'b0;
  logic out_vld, out_sop, out_eop, out_crc_ok;
  logic [7:0] out_data;
  logic [CW-1:0] rx_pkt_cnt, good_pkt_cnt, bad_pkt_cnt;

  always #5 clk = ~clk;

  gap_pkt_rx #(.NORM_GAP(NG), .SLOW_GAP(SG), .CNT_W(CW)) i_gap_pkt_rx (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .slow_mode(slow_mode), .char_tick(char_tick), .out_vld(out_vld),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_crc_ok(out_crc_ok), .rx_pkt_cnt(rx_pkt_cnt),
    .good_pkt_cnt(good_pkt_cnt), .bad_pkt_cnt(bad_pkt_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit       m_open = 0;
  bit [7:0] m_hold = 0;
  bit       m_first = 0;
  int       m_gap = 0;
  bit [15:0] m_crc = 0;
  int       m_rx = 0, m_good = 0, m_bad = 0;

  // bitwise reflected CRC, written independently of the RTL
  function automatic bit [15:0] bcrc(bit [15:0] c, bit [7:0] b);
    for (int k = 0; k < 8; k++) begin
      bit fb;
      fb = c[0] ^ b[k];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit [7:0] d, bit t);
    bit e_vld, e_sop, e_eop, e_ok;
    bit [7:0] e_data;
    int lim;
    e_vld = 0; e_sop = 0; e_eop = 0; e_ok = 0; e_data = 0;
    lim = slow_mode ? SG : NG;
    byte_vld = v; byte_data = d; char_tick = t;
    if (v) begin
      if (m_open) begin e_vld = 1; e_data = m_hold; e_sop = m_first; end
      m_crc = bcrc(m_open ? m_crc : 16'h0, d);
      m_first = !m_open; m_hold = d; m_open = 1; m_gap = 0;
    end else if (t && m_open) begin
      if (m_gap >= lim) begin
        e_vld = 1; e_eop = 1; e_data = m_hold; e_sop = m_first;
        e_ok = (m_crc == 16'h0);
        m_rx++; if (e_ok) m_good++; else m_bad++;
        m_open = 0; m_gap = 0;
      end else m_gap++;
    end
    @(negedge clk);
    byte_vld = 0; char_tick = 0;
    chk(out_vld == e_vld, (!v && !m_open && !e_eop) ? "R8 idle quiet" : "R2 valid", out_vld, e_vld);
    if (e_vld) begin
      chk(out_data == e_data, "R2 data", out_data, e_data);
      chk(out_sop == e_sop, "R3 sop", out_sop, e_sop);
      chk(out_eop == e_eop, slow_mode ? "R5 slow close" : "R4 normal close", out_eop, e_eop);
      if (e_eop) chk(out_crc_ok == e_ok, "R7 crc verdict", out_crc_ok, e_ok);
    end
    chk(rx_pkt_cnt == CW'(m_rx), "R9 rx count", rx_pkt_cnt, m_rx % (1 << CW));
    chk(good_pkt_cnt == CW'(m_good), "R9 good count", good_pkt_cnt, m_good % (1 << CW));
    chk(bad_pkt_cnt == CW'(m_bad), "R9 bad count", bad_pkt_cnt, m_bad % (1 << CW));
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(out_vld == 0 && out_sop == 0 && out_eop == 0 && out_crc_ok == 0, "R1 reset outputs",
        {out_vld, out_sop, out_eop, out_crc_ok}, 0);
    chk(rx_pkt_cnt == 0 && good_pkt_cnt == 0 && bad_pkt_cnt == 0, "R1 reset counters",
        rx_pkt_cnt + good_pkt_cnt + bad_pkt_cnt, 0);
    // R8 ticks with nothing open
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    for (int md = 0; md < 2; md++) begin
      int lim;
      slow_mode = md[0];
      lim = md ? SG : NG;
      for (int len = 1; len <= 6; len++) begin
        for (int kind = 0; kind < 3; kind++) begin
          bit [7:0] pk[$];
          bit [15:0] c;
          c = 0;
          pk.delete();
          for (int i = 0; i < len; i++) begin
            bit [7:0] b;
            b = 8'((len * 37 + i * 11 + md * 5 + kind * 3) & 255);
            pk.push_back(b);
            c = bcrc(c, b);
          end
          if (kind != 2) begin
            pk.push_back(c[7:0]);
            pk.push_back(c[15:8]);
          end
          if (kind == 1) pk[pk.size() - 1] = pk[pk.size() - 1] ^ 8'h20;
          for (int i = 0; i < pk.size(); i++) begin
            int nt;
            // R6: tick together with the byte is ignored
            step(1, pk[i], (i % 3) == 1);
            // R6: gap of 0..limit ticks keeps the packet open
            nt = (i + len + kind) % (lim + 1);
            if (i == 0) nt = lim;
            if (i < pk.size() - 1)
              for (int j = 0; j < nt; j++) begin
                step(0, 0, 1);
                if (j % 2 == 0) step(0, 0, 0);
              end
          end
          // close: lim+1 ticks, then an extra idle tick (R8)
          for (int j = 0; j < lim + 2; j++) begin
            step(0, 0, 1);
            step(0, 0, 0);
          end
        end
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule